// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is a single channel of a PC-style DMA engine. A peripheral raises a request. If the channel is not masked, the sequencer asks the bus owner for the bus with a hold request and waits for the hold acknowledge. It then runs one bus transfer. During that transfer it puts the current memory address on the address output and asserts the device acknowledge. It also drives the command strobes that the programmed transfer kind calls for. When the transfer ends, the channel releases the hold request. Each transfer moves a single word, so a device that wants more words keeps its request up.

Software programs the channel through a small write port. The port sets a mode word, a base address, a base word count and a request mask bit. A write to a base register also loads the matching current register. On every transfer the current address steps up or down and the current word count steps down. The channel reaches terminal count on the transfer that finds the count at zero, at which point the count wraps to all ones. Terminal count produces a one-clock pulse. After it, the channel either reloads its current registers from the base registers or masks itself.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, the channel drives these values: hold request low, terminal count low, all four active-low strobes high, and the device acknowledge high (acknowledge is active-low after reset, so this is inactive). The request mask is set after reset.
- R2: While the mask bit is set, a device request never raises the hold request. The mask is written with prog_sel = 3, and its value is taken from prog_data[0].
- R3: An unmasked request raises the hold request one clock later. After the hold acknowledge is sampled, the channel enters an address phase for one clock and then a transfer phase. The device acknowledge is active and the current address is valid in both phases. No strobe is active in the address phase.
- R4: A read transfer (mode bits [1:0] = 10) holds memr_n_o and iow_n_o low during the transfer phase and keeps the other two strobes high.
- R5: A write transfer (mode bits [1:0] = 01) holds ior_n_o and memw_n_o low during the transfer phase and keeps the other two strobes high.
- R6: A verify transfer (mode bits [1:0] = 00), and the unused code 11, run the same handshake but assert no strobe. They ignore ready_i, and their transfer phase lasts exactly one clock.
- R7: During a read or write, each clock on which ready_i is low adds one wait clock to the transfer phase, and the strobes stay asserted through the wait.
- R8: After each transfer, the current address steps by one. It increments when mode bit 3 is 0 and decrements when mode bit 3 is 1.
- R9: The word count steps down on each transfer. The transfer that finds the count at zero is the terminal one. On the clock after that transfer, tc_o is high for exactly one clock.
- R10: When mode bit 2 (auto-initialize) is set, terminal count reloads the current address and the current count from the base registers, and the mask stays clear.
- R11: When auto-initialize is clear, terminal count sets the mask bit. Further requests are then ignored until software clears the mask.
- R12: When mode bit 4 is set, the device acknowledge is active-high, so it is low when idle.
- R13: The write port selects a register with prog_sel. Code 0 writes the mode from prog_data[4:0]. Code 1 writes the base address and code 2 writes the base count, and each of these also loads the matching current register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_we | input | 1 | Register write strobe |
| prog_sel | input | 2 | Register select: 0 mode, 1 base address, 2 base count, 3 mask |
| prog_data | input | PROG_W | Write data |
| dreq_i | input | 1 | Device request |
| hlda_i | input | 1 | Hold acknowledge from the bus owner |
| ready_i | input | 1 | Bus ready; low stretches read and write transfers |
| hrq_o | output | 1 | Hold request |
| dack_o | output | 1 | Device acknowledge, polarity set by mode bit 4 |
| addr_o | output | ADDR_W | Current memory address |
| memr_n_o | output | 1 | Memory read strobe, active low |
| memw_n_o | output | 1 | Memory write strobe, active low |
| ior_n_o | output | 1 | I/O read strobe, active low |
| iow_n_o | output | 1 | I/O write strobe, active low |
| tc_o | output | 1 | Terminal count pulse |

## Verification
The bench pushes several cases through the channel:
- A verify transfer with ready held low. A design that honours ready in verify mode would hang in the transfer phase.
- Read and write transfers with wait states. Dropping the strobes early, or ignoring ready, shows up as a strobe mismatch.
- The terminal transfer with count zero and auto-initialize off. An off-by-one in the count would move the tc_o pulse, and a missing self-mask would let the next request raise a hold.
- The unused type code, together with decrement, active-high acknowledge and auto-reload. A wrong reload source, or a wrong acknowledge level, is seen on addr_o and dack_o.

// File: rtl/dma_chan_pkg.sv
// Shared types for the DMA channel sequencer.
// Assumes the mode word occupies prog_data[4:0].
package dma_chan_pkg;

    typedef enum logic [1:0] {
        XT_VERIFY  = 2'b00,
        XT_WRITE   = 2'b01,
        XT_READ    = 2'b10,
        XT_UNUSED  = 2'b11
    } xfer_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HOLD,
        ST_ADDR,
        ST_XFER
    } state_e;

    typedef struct packed {
        logic  ack_hi;    // bit 4: acknowledge active high
        logic  dec;       // bit 3: address decrements
        logic  autoinit;  // bit 2: reload on terminal count
        xfer_e kind;      // bits 1:0: transfer type
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    localparam logic [1:0] SEL_MODE      = 2'd0;
    localparam logic [1:0] SEL_BASE_ADDR = 2'd1;
    localparam logic [1:0] SEL_BASE_CNT  = 2'd2;
    localparam logic [1:0] SEL_MASK      = 2'd3;

endpackage

// File: rtl/dma_chan_regs.sv
// Programming registers: mode word, base address, base count and request mask.
// A base write also pulses a load towards the current registers.
// Terminal count without auto-initialize sets the mask.
// Assumes PROG_W >= ADDR_W, CNT_W and MODE_W.
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int PROG_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_we,
    input  logic [1:0]        prog_sel,
    input  logic [PROG_W-1:0] prog_data,
    input  logic              tc_evt,
    output mode_t             mode,
    output logic [ADDR_W-1:0] base_addr,
    output logic [CNT_W-1:0]  base_cnt,
    output logic              mask,
    output logic              load_addr,
    output logic              load_cnt
);

    assign load_addr = prog_we && (prog_sel == SEL_BASE_ADDR);
    assign load_cnt  = prog_we && (prog_sel == SEL_BASE_CNT);

    // Mode word and base registers take software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode      <= '0;
            base_addr <= '0;
            base_cnt  <= '0;
        end else begin
            if (prog_we && prog_sel == SEL_MODE)
                mode <= mode_t'(prog_data[MODE_W-1:0]);
            if (load_addr)
                base_addr <= prog_data[ADDR_W-1:0];
            if (load_cnt)
                base_cnt <= prog_data[CNT_W-1:0];
        end
    end

    // Mask: set at reset, written by software, self-set on a non-reloading terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask <= 1'b1;
        else if (prog_we && prog_sel == SEL_MASK)
            mask <= prog_data[0];
        else if (tc_evt && !mode.autoinit)
            mask <= 1'b1;
    end

endmodule

// File: rtl/dma_chan_ctr.sv
// Current address and current word count.
// Steps once per completed transfer, detects terminal count (count at zero when stepped)
// and reloads from the base registers when auto-initialize is set.
module dma_chan_ctr #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_addr,
    input  logic              load_cnt,
    input  logic [ADDR_W-1:0] new_addr,
    input  logic [CNT_W-1:0]  new_cnt,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [CNT_W-1:0]  base_cnt,
    input  logic              step,
    input  logic              dec,
    input  logic              autoinit,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_cnt,
    output logic              tc_evt,
    output logic              tc_o
);

    logic [ADDR_W-1:0] addr_next;

    assign tc_evt = step && (cur_cnt == '0);

    // Pick the address step direction from the mode bit.
    always_comb begin
        if (dec)
            addr_next = cur_addr - ADDR_W'(1);
        else
            addr_next = cur_addr + ADDR_W'(1);
    end

    // Current address: software load, then reload, then step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_addr <= '0;
        else if (load_addr)
            cur_addr <= new_addr;
        else if (tc_evt && autoinit)
            cur_addr <= base_addr;
        else if (step)
            cur_addr <= addr_next;
    end

    // Current count: software load, then reload, then decrement (wraps past zero).
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_cnt <= '0;
        else if (load_cnt)
            cur_cnt <= new_cnt;
        else if (tc_evt && autoinit)
            cur_cnt <= base_cnt;
        else if (step)
            cur_cnt <= cur_cnt - CNT_W'(1);
    end

    // Registered one-clock terminal count pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tc_o <= 1'b0;
        else
            tc_o <= tc_evt;
    end

    // R9
    tc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc_o |=> !tc_o);

endmodule

// File: rtl/dma_chan_fsm.sv
// Bus handshake and cycle sequencer: idle, hold request, address phase, transfer phase.
// One word moves per hold. Read and write are stretched by ready_i, and verify is not.
// Strobes and acknowledge are decoded from the state.
module dma_chan_fsm
    import dma_chan_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  dreq_i,
    input  logic  hlda_i,
    input  logic  ready_i,
    input  logic  mask_i,
    input  xfer_e kind,
    input  logic  ack_hi,
    output logic  hrq_o,
    output logic  dack_o,
    output logic  memr_n_o,
    output logic  memw_n_o,
    output logic  ior_n_o,
    output logic  iow_n_o,
    output logic  xfer_done
);

    state_e state;
    logic   real_xfer;
    logic   cmd_on;
    logic   ack_active;

    assign real_xfer  = (kind == XT_READ) || (kind == XT_WRITE);
    assign xfer_done  = (state == ST_XFER) && (!real_xfer || ready_i);
    assign cmd_on     = (state == ST_XFER) && real_xfer;
    assign ack_active = (state == ST_ADDR) || (state == ST_XFER);

    // Advance through the bus handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (dreq_i && !mask_i) state <= ST_HOLD;
                ST_HOLD: if (hlda_i)            state <= ST_ADDR;
                ST_ADDR:                        state <= ST_XFER;
                ST_XFER: if (xfer_done)         state <= ST_IDLE;
                default:                        state <= ST_IDLE;
            endcase
        end
    end

    // Decode the bus outputs from the state and transfer kind.
    always_comb begin
        hrq_o    = (state != ST_IDLE);
        dack_o   = ack_hi ? ack_active : !ack_active;
        memr_n_o = !(cmd_on && kind == XT_READ);
        iow_n_o  = !(cmd_on && kind == XT_READ);
        ior_n_o  = !(cmd_on && kind == XT_WRITE);
        memw_n_o = !(cmd_on && kind == XT_WRITE);
    end

    // R2
    hrq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hrq_o) |-> $past(!mask_i));

    // R4 R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!memr_n_o && !memw_n_o) && !(!ior_n_o && !iow_n_o));

    // R7
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(memr_n_o && ior_n_o) && !ready_i) |=> !(memr_n_o && ior_n_o));

    // R3
    strobe_under_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(memr_n_o && ior_n_o) |-> hrq_o);

endmodule

// File: rtl/dma_chan_seq.sv
// Top of one DMA channel: programming registers, current counters and the bus sequencer.
// Assumes PROG_W is at least ADDR_W, CNT_W and the mode width.
module dma_chan_seq
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int PROG_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_we,
    input  logic [1:0]        prog_sel,
    input  logic [PROG_W-1:0] prog_data,
    input  logic              dreq_i,
    input  logic              hlda_i,
    input  logic              ready_i,
    output logic              hrq_o,
    output logic              dack_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              memr_n_o,
    output logic              memw_n_o,
    output logic              ior_n_o,
    output logic              iow_n_o,
    output logic              tc_o
);

    mode_t             mode;
    logic [ADDR_W-1:0] base_addr;
    logic [CNT_W-1:0]  base_cnt;
    logic [CNT_W-1:0]  cur_cnt;
    logic              mask;
    logic              load_addr;
    logic              load_cnt;
    logic              tc_evt;
    logic              step;

    dma_chan_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PROG_W(PROG_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_we   (prog_we),
        .prog_sel  (prog_sel),
        .prog_data (prog_data),
        .tc_evt    (tc_evt),
        .mode      (mode),
        .base_addr (base_addr),
        .base_cnt  (base_cnt),
        .mask      (mask),
        .load_addr (load_addr),
        .load_cnt  (load_cnt)
    );

    dma_chan_ctr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_addr (load_addr),
        .load_cnt  (load_cnt),
        .new_addr  (prog_data[ADDR_W-1:0]),
        .new_cnt   (prog_data[CNT_W-1:0]),
        .base_addr (base_addr),
        .base_cnt  (base_cnt),
        .step      (step),
        .dec       (mode.dec),
        .autoinit  (mode.autoinit),
        .cur_addr  (addr_o),
        .cur_cnt   (cur_cnt),
        .tc_evt    (tc_evt),
        .tc_o      (tc_o)
    );

    dma_chan_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .dreq_i    (dreq_i),
        .hlda_i    (hlda_i),
        .ready_i   (ready_i),
        .mask_i    (mask),
        .kind      (mode.kind),
        .ack_hi    (mode.ack_hi),
        .hrq_o     (hrq_o),
        .dack_o    (dack_o),
        .memr_n_o  (memr_n_o),
        .memw_n_o  (memw_n_o),
        .ior_n_o   (ior_n_o),
        .iow_n_o   (iow_n_o),
        .xfer_done (step)
    );

    // R10
    reload_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_o && mode.autoinit) |-> (cur_cnt == base_cnt));

    // R11
    self_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_o && !mode.autoinit && !$past(prog_we)) |-> mask);

endmodule

// File: tb/dma_chan_seq_bench.sv
// Directed bench for dma_chan_seq: one task per scenario, reference model kept in the bench.
module dma_chan_seq_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_we = 1'b0;
    logic [1:0]  prog_sel = '0;
    logic [15:0] prog_data = '0;
    logic        dreq_i = 1'b0;
    logic        hlda_i = 1'b0;
    logic        ready_i = 1'b1;
    logic        hrq_o, dack_o, memr_n_o, memw_n_o, ior_n_o, iow_n_o, tc_o;
    logic [15:0] addr_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model
    logic [15:0] m_addr, m_base_addr, m_cnt, m_base_cnt;
    logic [4:0]  m_mode;
    logic        m_mask;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan_seq u_dma_chan_seq (
        .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_sel(prog_sel),
        .prog_data(prog_data), .dreq_i(dreq_i), .hlda_i(hlda_i), .ready_i(ready_i),
        .hrq_o(hrq_o), .dack_o(dack_o), .addr_o(addr_o), .memr_n_o(memr_n_o),
        .memw_n_o(memw_n_o), .ior_n_o(ior_n_o), .iow_n_o(iow_n_o), .tc_o(tc_o)
    );

    function automatic logic [3:0] strobes();
        return {memr_n_o, memw_n_o, ior_n_o, iow_n_o};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic prog(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        prog_we = 1'b1; prog_sel = sel; prog_data = data;
        @(negedge clk);
        prog_we = 1'b0;
        case (sel)
            2'd0: m_mode = data[4:0];
            2'd1: begin m_base_addr = data; m_addr = data; end
            2'd2: begin m_base_cnt = data; m_cnt = data; end
            default: m_mask = data[0];
        endcase
    endtask

    // R1: reset values at the ports
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_mode = '0; m_addr = '0; m_base_addr = '0; m_cnt = '0; m_base_cnt = '0; m_mask = 1'b1;
        @(negedge clk);
        check("R1 hrq", {31'd0, hrq_o}, 32'd0);
        check("R1 dack", {31'd0, dack_o}, 32'd1);
        check("R1 strobes", {28'd0, strobes()}, 32'hF);
        check("R1 tc", {31'd0, tc_o}, 32'd0);
    endtask

    // R2 / R11: requests are ignored while masked
    task automatic t_masked(input string req);
        dreq_i = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(req, {31'd0, hrq_o}, 32'd0);
        end
        dreq_i = 1'b0;
        @(negedge clk);
    endtask

    // One full transfer; expected values come from the bench model.
    task automatic do_xfer(input int waits, input string req);
        logic [1:0] kind;
        logic       real_x, act, tcx;
        logic [3:0] exp_str;
        kind   = m_mode[1:0];
        real_x = (kind == 2'b01) || (kind == 2'b10);
        act    = m_mode[4];
        exp_str = (kind == 2'b10) ? 4'b0110 : (kind == 2'b01) ? 4'b1001 : 4'b1111;
        @(negedge clk);
        dreq_i = 1'b1;
        @(negedge clk);
        check({"R3 hrq ", req}, {31'd0, hrq_o}, 32'd1);
        check({"R3 dack idle ", req}, {31'd0, dack_o}, {31'd0, !act});
        hlda_i  = 1'b1;
        ready_i = (waits == 0);
        @(negedge clk);
        check({"R3 dack addr ", req}, {31'd0, dack_o}, {31'd0, act});
        check({"R3 addr phase strobes ", req}, {28'd0, strobes()}, 32'hF);
        check({"R8 addr ", req}, {16'd0, addr_o}, {16'd0, m_addr});
        @(negedge clk);
        dreq_i = 1'b0;
        check({"R4 R5 R6 strobes ", req}, {28'd0, strobes()}, {28'd0, exp_str});
        check({"R3 dack xfer ", req}, {31'd0, dack_o}, {31'd0, act});
        if (real_x) begin
            for (int i = 0; i < waits; i++) begin
                @(negedge clk);
                check({"R7 wait strobes ", req}, {28'd0, strobes()}, {28'd0, exp_str});
                if (i == waits - 1) ready_i = 1'b1;
            end
        end
        @(negedge clk);
        ready_i = 1'b1;
        hlda_i  = 1'b0;
        tcx = (m_cnt == 16'd0);
        if (tcx && m_mode[2]) begin
            m_addr = m_base_addr; m_cnt = m_base_cnt;
        end else begin
            m_addr = m_mode[3] ? m_addr - 16'd1 : m_addr + 16'd1;
            m_cnt  = m_cnt - 16'd1;
            if (tcx) m_mask = 1'b1;
        end
        check({"R6 R7 end hrq ", req}, {31'd0, hrq_o}, 32'd0);
        check({"R9 tc ", req}, {31'd0, tc_o}, {31'd0, tcx});
        check({"R8 R10 next addr ", req}, {16'd0, addr_o}, {16'd0, m_addr});
        check({"R3 end strobes ", req}, {28'd0, strobes()}, 32'hF);
        @(negedge clk);
        check({"R9 tc one clock ", req}, {31'd0, tc_o}, 32'd0);
    endtask

    // R4 R8 R13: read transfer, increment, base write loads current
    task automatic t_read();
        prog(2'd0, 16'h0002);
        prog(2'd1, 16'h1000);
        prog(2'd2, 16'h0002);
        prog(2'd3, 16'h0000);
        check("R13 addr load", {16'd0, addr_o}, 32'h1000);
        do_xfer(0, "read");
    endtask

    // R5 R7: write transfer with two wait clocks
    task automatic t_write_wait();
        prog(2'd0, 16'h0001);
        do_xfer(2, "write");
    endtask

    // R6 R9 R11: verify with ready low, terminal count, self mask
    task automatic t_verify_tc();
        prog(2'd0, 16'h0000);
        ready_i = 1'b0;
        do_xfer(3, "verify");
        check("R11 mask model", {31'd0, m_mask}, 32'd1);
        t_masked("R11 masked after tc");
    endtask

    // R6 R8 R10 R12: unused code, decrement, auto-reload, active-high acknowledge
    task automatic t_autoinit();
        prog(2'd0, 16'h001F);
        prog(2'd1, 16'h2000);
        prog(2'd2, 16'h0001);
        prog(2'd3, 16'h0000);
        check("R12 idle dack high-active", {31'd0, dack_o}, 32'd0);
        do_xfer(1, "unused dec");
        do_xfer(0, "reload tc");
        check("R10 addr reloaded", {16'd0, addr_o}, 32'h2000);
        do_xfer(0, "after reload");
    endtask

    initial begin
        t_reset();
        t_masked("R2 masked after reset");
        t_read();
        t_write_wait();
        t_verify_tc();
        t_autoinit();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule